// File: doc/BRIEF.md
# Type-C Port Register Front End

This block is the software-visible register layer of a Type-C port controller. A processor reaches it through a small request/response bus that moves 32-bit words. Every request is accepted in the cycle it is presented, and the response comes back one cycle later. Behind the bus there are four locations:

- a control word, which triggers a controller soft reset when one exact key is written to it;
- a PHY control word, which drives the analog front end;
- a PHY status word, which reports synchronized comparator and charger-detect inputs;
- a read-only version word.

A separate sideband lets the port policy logic request a CC termination. Sink pull-down and default-current pull-up requests become the 2-bit pull-up current code inside the PHY control word. Stronger pull-up requests are refused and flagged as an error. The block is meant to sit between the peripheral interconnect and the analog Type-C PHY.

Top module: `typec_port_regs`

## Requirements
- R1: `req_ready_o` is always high. Every cycle with `req_valid_i` high produces exactly one response, with `rsp_valid_o` high in the following cycle. No response appears without a request.
- R2: The accessible word offsets are 0x80 (control), 0xA0 (PHY control) and 0xA4 (PHY status); these take both reads and writes. Offset 0xFC (version) may only be read. Any other address, a misaligned address (low two bits nonzero) or a write to 0xFC returns `rsp_err_o`=1 with `rsp_rdata_o`=0 and changes no state. Write responses carry `rsp_rdata_o`=0.
- R3: Writing 32'h54434301 to the control word raises `soft_rst_o` for exactly the one cycle after the write and clears the PHY control word to zero in that same edge. Any other value written there is ignored. Reading the control word returns 0.
- R4: The PHY control word keeps only bits [29:24], the pull-up current field at [13:12] and the comparator threshold selector at [10:8]. All other bits read 0. The current codes are 0 = off, 1 = default (0.5 A), 2 = 1.5 A and 3 = 3.0 A. The word is driven on `phy_ctrl_o` and read back at 0xA0.
- R5: When `term_valid_i` is high, request code 0 (sink pull-down) writes current code 0 and request code 1 (default-current pull-up) writes current code 1. The change takes effect at the next edge, and all other PHY control bits are unchanged.
- R6: Request codes 2 and 3 (1.5 A and 3.0 A pull-up) are refused. `term_err_o` goes high for the one cycle after the request, and the PHY control word is not changed by the request.
- R7: PHY status bits [4:0] show `cc_raw_i` after a 2-flop synchronizer, so a read answered at edge e shows the input sampled at edge e-2. Bit 4 is CC2 detect, bit 3 is CC1 detect, bit 2 is charger detect, bit 1 is D- and bit 0 is D+. Writes to 0xA4 respond without error and have no effect.
- R8: When an accepted termination request meets a bus write to 0xA0 in the same cycle, the word takes the bus data except the current field, which takes the termination code. A refused request leaves the bus write intact. A key write wins over any termination request in the same cycle, and the word is cleared.
- R9: Reading 0xFC returns the VERSION parameter (default 32'h0001_0200).
- R10: After reset, `rsp_valid_o`, `rsp_err_o`, `rsp_rdata_o`, `term_err_o`, `soft_rst_o` and `phy_ctrl_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Bus request valid |
| req_ready_o | output | 1 | Bus request ready (always 1) |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W (8) | Byte address |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Response valid, one cycle after request |
| rsp_err_o | output | 1 | Access refused |
| rsp_rdata_o | output | 32 | Read data |
| term_valid_i | input | 1 | Termination request strobe |
| term_req_i | input | 2 | 0 sink, 1 default pull-up, 2 1.5 A, 3 3.0 A |
| term_err_o | output | 1 | Termination request refused |
| cc_raw_i | input | 5 | Asynchronous comparator and detect inputs |
| phy_ctrl_o | output | 32 | PHY control word to the analog front end |
| soft_rst_o | output | 1 | Controller soft reset pulse |

## Verification
Two functions can touch the PHY control word in the same cycle: a bus write to 0xA0 and a termination request on the sideband. The bench lines them up on the same edge for three cases: an accepted request, a refused request, and a request that coincides with the reset key. Each result is judged against the merge rule of R8. A behavioural model predicts the whole word and every response on every clock, so a wrong priority shows up at once on `phy_ctrl_o`. The same mismatch also appears on the next read-back.

// File: rtl/typec_regs_pkg.sv
package typec_regs_pkg;
  localparam int unsigned DATA_W = 32;
  localparam logic [11:0] OFF_CTRL = 12'h080;
  localparam logic [11:0] OFF_PHY  = 12'h0A0;
  localparam logic [11:0] OFF_STAT = 12'h0A4;
  localparam logic [11:0] OFF_VER  = 12'h0FC;
  localparam logic [DATA_W-1:0] RST_KEY   = 32'h5443_4301;
  localparam logic [DATA_W-1:0] PHY_WMASK = 32'h3F00_3700;
  localparam int unsigned IP_LO = 12;
  localparam int unsigned IP_HI = 13;

  typedef enum logic [1:0] {
    TERM_SNK     = 2'd0,
    TERM_SRC_DEF = 2'd1,
    TERM_SRC_1P5 = 2'd2,
    TERM_SRC_3P0 = 2'd3
  } term_req_e;

  typedef struct packed {
    logic ctrl;
    logic phy;
    logic stat;
    logic ver;
    logic err;
  } dec_t;
endpackage

// File: rtl/typec_addr_dec.sv
module typec_addr_dec
  import typec_regs_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              write_i,
  output dec_t              dec_o
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_PHY  = ADDR_W'(OFF_PHY);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);
  localparam logic [ADDR_W-1:0] A_VER  = ADDR_W'(OFF_VER);

  logic hit;
  always_comb begin
    dec_o      = '0;
    dec_o.ctrl = (addr_i == A_CTRL);
    dec_o.phy  = (addr_i == A_PHY);
    dec_o.stat = (addr_i == A_STAT);
    dec_o.ver  = (addr_i == A_VER) && !write_i;
    hit        = dec_o.ctrl | dec_o.phy | dec_o.stat | dec_o.ver;
    dec_o.err  = !hit;
  end
endmodule

// File: rtl/typec_term_map.sv
module typec_term_map
  import typec_regs_pkg::*;
(
  input  logic [1:0] req_i,
  output logic       ok_o,
  output logic [1:0] code_o
);
  always_comb begin
    ok_o   = 1'b0;
    code_o = 2'd0;
    unique case (term_req_e'(req_i))
      TERM_SNK:     begin ok_o = 1'b1; code_o = 2'd0; end
      TERM_SRC_DEF: begin ok_o = 1'b1; code_o = 2'd1; end
      default:      begin ok_o = 1'b0; code_o = 2'd0; end
    endcase
  end
endmodule

// File: rtl/typec_cc_sync.sv
module typec_cc_sync #(
  parameter int unsigned WIDTH  = 5,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg[s] <= '0;
      else if (s == 0) stg[s] <= d_i;
      else stg[s] <= stg[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/typec_port_regs.sv
module typec_port_regs
  import typec_regs_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned STAT_W      = 5,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [31:0] VERSION     = 32'h0001_0200
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [31:0]       req_wdata_i,
  output logic              rsp_valid_o,
  output logic              rsp_err_o,
  output logic [31:0]       rsp_rdata_o,
  input  logic              term_valid_i,
  input  logic [1:0]        term_req_i,
  output logic              term_err_o,
  input  logic [STAT_W-1:0] cc_raw_i,
  output logic [31:0]       phy_ctrl_o,
  output logic              soft_rst_o
);
  localparam int unsigned PAD_W = DATA_W - STAT_W;

  dec_t              dec;
  logic              term_ok;
  logic [1:0]        term_code;
  logic [STAT_W-1:0] stat_sync;
  logic [31:0]       phy_q, phy_d, rd_mux;
  logic              key_hit, wr_phy, rd_ok;

  typec_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i (req_addr_i),
    .write_i(req_write_i),
    .dec_o  (dec)
  );

  typec_term_map u_term (
    .req_i (term_req_i),
    .ok_o  (term_ok),
    .code_o(term_code)
  );

  typec_cc_sync #(.WIDTH(STAT_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (cc_raw_i),
    .q_o   (stat_sync)
  );

  assign req_ready_o = 1'b1;
  assign key_hit = req_valid_i && req_write_i && dec.ctrl && (req_wdata_i == RST_KEY);
  assign wr_phy  = req_valid_i && req_write_i && dec.phy;
  assign rd_ok   = req_valid_i && !req_write_i && !dec.err;

  always_comb begin
    phy_d = phy_q;
    if (key_hit) begin
      phy_d = '0;
    end else begin
      if (wr_phy) phy_d = req_wdata_i & PHY_WMASK;
      // accepted termination overrides the current field of a same-cycle write
      if (term_valid_i && term_ok) phy_d[IP_HI:IP_LO] = term_code;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (dec.phy)  rd_mux = phy_q;
    if (dec.stat) rd_mux = {{PAD_W{1'b0}}, stat_sync};
    if (dec.ver)  rd_mux = VERSION;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phy_q       <= '0;
      rsp_valid_o <= 1'b0;
      rsp_err_o   <= 1'b0;
      rsp_rdata_o <= '0;
      term_err_o  <= 1'b0;
      soft_rst_o  <= 1'b0;
    end else begin
      phy_q       <= phy_d;
      rsp_valid_o <= req_valid_i;
      rsp_err_o   <= req_valid_i && dec.err;
      rsp_rdata_o <= rd_ok ? rd_mux : '0;
      term_err_o  <= term_valid_i && !term_ok;
      soft_rst_o  <= key_hit;
    end
  end

  assign phy_ctrl_o = phy_q;
endmodule

// File: rtl/typec_port_regs_chk.sv
module typec_port_regs_chk
  import typec_regs_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_write_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic [31:0]       req_wdata_i,
  input logic              term_valid_i,
  input logic [1:0]        term_req_i,
  input logic              rsp_valid_o,
  input logic              rsp_err_o,
  input logic [31:0]       rsp_rdata_o,
  input logic              term_err_o,
  input logic [31:0]       phy_ctrl_o,
  input logic              soft_rst_o
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);

  a_r1_rsp_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);

  a_r1_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $past(req_valid_i));

  a_r2_err_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_err_o) |-> (rsp_rdata_o == '0));

  a_r3_key_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_o |-> $past(req_valid_i && req_write_i && req_addr_i == A_CTRL
                         && req_wdata_i == RST_KEY));

  a_r3_clears_phy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_o |-> (phy_ctrl_o == '0));

  a_r5_sink_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (term_valid_i && term_req_i == 2'd0 && !req_valid_i)
      |=> (phy_ctrl_o[IP_HI:IP_LO] == 2'd0));

  a_r6_reject_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (term_err_o && !$past(req_valid_i && req_write_i)) |-> $stable(phy_ctrl_o));
endmodule

bind typec_port_regs typec_port_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_write_i (req_write_i),
  .req_addr_i  (req_addr_i),
  .req_wdata_i (req_wdata_i),
  .term_valid_i(term_valid_i),
  .term_req_i  (term_req_i),
  .rsp_valid_o (rsp_valid_o),
  .rsp_err_o   (rsp_err_o),
  .rsp_rdata_o (rsp_rdata_o),
  .term_err_o  (term_err_o),
  .phy_ctrl_o  (phy_ctrl_o),
  .soft_rst_o  (soft_rst_o)
);

// File: tb/typec_port_regs_tb.sv
module typec_port_regs_tb;
  localparam int SYNC = 2;
  localparam logic [31:0] VER = 32'h0001_0200;
  localparam logic [31:0] KEY = 32'h5443_4301;
  localparam logic [31:0] MSK = 32'h3F00_3700;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic req_valid = 0, req_write = 0, term_valid = 0;
  logic [7:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [1:0] term_req = '0;
  logic [4:0] cc_raw = '0;
  logic req_ready, rsp_valid, rsp_err, term_err, soft_rst;
  logic [31:0] rsp_rdata, phy_ctrl;

  int total = 0, bad = 0;
  bit done = 0;

  logic [31:0] m_phy = '0;
  logic [4:0]  raw_q[$];

  always #2 clk = ~clk;

  typec_port_regs u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_err_o(rsp_err), .rsp_rdata_o(rsp_rdata),
    .term_valid_i(term_valid), .term_req_i(term_req), .term_err_o(term_err),
    .cc_raw_i(cc_raw), .phy_ctrl_o(phy_ctrl), .soft_rst_o(soft_rst)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input logic v, input logic w, input logic [7:0] a,
                     input logic [31:0] d, input logic tv, input logic [1:0] tc,
                     input logic [4:0] raw, input string tag);
    logic [31:0] e_rd;
    logic e_err, e_key, e_terr;
    bit acc, ro_ver;
    req_valid = v; req_write = w; req_addr = a; req_wdata = d;
    term_valid = tv; term_req = tc; cc_raw = raw;
    @(posedge clk);
    raw_q.push_back(raw);
    ro_ver = (a == 8'hFC) && !w;
    acc = (a == 8'h80) || (a == 8'hA0) || (a == 8'hA4) || ro_ver;
    e_err = v && !acc;
    e_rd = '0;
    if (v && !w && acc) begin
      if (a == 8'hA0) e_rd = m_phy;
      else if (a == 8'hA4) e_rd = {27'd0, raw_q[raw_q.size()-1-SYNC]};
      else if (a == 8'hFC) e_rd = VER;
    end
    e_key = v && w && (a == 8'h80) && (d == KEY);
    e_terr = tv && (tc > 2'd1);
    if (e_key) m_phy = '0;
    else begin
      if (v && w && a == 8'hA0) m_phy = d & MSK;
      if (tv && tc <= 2'd1) m_phy[13:12] = tc;
    end
    @(negedge clk);
    chk(rsp_valid === v, tag, "rsp_valid", {31'd0, rsp_valid}, {31'd0, v});
    chk(rsp_err === e_err, tag, "rsp_err", {31'd0, rsp_err}, {31'd0, e_err});
    chk(rsp_rdata === e_rd, tag, "rsp_rdata", rsp_rdata, e_rd);
    chk(soft_rst === e_key, tag, "soft_rst", {31'd0, soft_rst}, {31'd0, e_key});
    chk(term_err === e_terr, tag, "term_err", {31'd0, term_err}, {31'd0, e_terr});
    chk(phy_ctrl === m_phy, tag, "phy_ctrl", phy_ctrl, m_phy);
    chk(req_ready === 1'b1, tag, "ready", {31'd0, req_ready}, 32'd1);
  endtask

  task automatic idle(input int n, input logic [4:0] raw);
    for (int i = 0; i < n; i++) cyc(0, 0, 8'h00, 0, 0, 0, raw, "R1");
  endtask

  initial begin
    for (int i = 0; i <= SYNC; i++) raw_q.push_back(5'd0);
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(rsp_valid === 0 && rsp_err === 0 && rsp_rdata === 0, "R10", "rsp", rsp_rdata, 0);
    chk(soft_rst === 0 && term_err === 0, "R10", "pulses", {30'd0, soft_rst, term_err}, 0);
    chk(phy_ctrl === 0, "R10", "phy_ctrl", phy_ctrl, 0);
    rst_ni = 1'b1;
    idle(2, 5'd0);
    // R2 / R3 / R9 basic reads
    cyc(1, 0, 8'h80, 0, 0, 0, 5'd0, "R3");
    cyc(1, 0, 8'hA0, 0, 0, 0, 5'd0, "R4");
    cyc(1, 0, 8'hFC, 0, 0, 0, 5'd0, "R9");
    cyc(1, 0, 8'hA4, 0, 0, 0, 5'd0, "R7");
    // R4 masked write and readback
    cyc(1, 1, 8'hA0, 32'hFFFF_FFFF, 0, 0, 5'd0, "R4");
    cyc(1, 0, 8'hA0, 0, 0, 0, 5'd0, "R4");
    cyc(1, 1, 8'hA0, 32'h0000_3200, 0, 0, 5'd0, "R4");
    // R5 accepted terminations
    cyc(0, 0, 0, 0, 1, 2'd0, 5'd0, "R5");
    cyc(0, 0, 0, 0, 1, 2'd1, 5'd0, "R5");
    cyc(1, 0, 8'hA0, 0, 0, 0, 5'd0, "R5");
    // R6 refused terminations
    cyc(0, 0, 0, 0, 1, 2'd2, 5'd0, "R6");
    cyc(0, 0, 0, 0, 1, 2'd3, 5'd0, "R6");
    cyc(1, 0, 8'hA0, 0, 0, 0, 5'd0, "R6");
    // R2 illegal accesses
    cyc(1, 0, 8'h84, 0, 0, 0, 5'd0, "R2");
    cyc(1, 1, 8'h00, 32'hFFFF_FFFF, 0, 0, 5'd0, "R2");
    cyc(1, 1, 8'hA1, 32'hFFFF_FFFF, 0, 0, 5'd0, "R2");
    cyc(1, 0, 8'hA2, 0, 0, 0, 5'd0, "R2");
    cyc(1, 1, 8'hFC, 32'h1234_5678, 0, 0, 5'd0, "R2");
    cyc(1, 0, 8'hFC, 0, 0, 0, 5'd0, "R9");
    cyc(1, 0, 8'hA0, 0, 0, 0, 5'd0, "R2");
    // R3 control writes
    cyc(1, 1, 8'h80, KEY ^ 32'h1, 0, 0, 5'd0, "R3");
    cyc(1, 1, 8'h80, 32'h0, 0, 0, 5'd0, "R3");
    cyc(1, 1, 8'h80, KEY, 0, 0, 5'd0, "R3");
    cyc(0, 0, 0, 0, 0, 0, 5'd0, "R3");
    cyc(1, 0, 8'hA0, 0, 0, 0, 5'd0, "R3");
    // R7 status path and latency
    idle(4, 5'b11010);
    cyc(1, 0, 8'hA4, 0, 0, 0, 5'b11010, "R7");
    cyc(1, 1, 8'hA4, 32'h0, 0, 0, 5'b11010, "R7");
    cyc(1, 0, 8'hA4, 0, 0, 0, 5'b00101, "R7");
    cyc(1, 0, 8'hA4, 0, 0, 0, 5'b01001, "R7");
    cyc(1, 0, 8'hA4, 0, 0, 0, 5'b01001, "R7");
    cyc(1, 0, 8'hA4, 0, 0, 0, 5'b01001, "R7");
    // R8 collisions
    cyc(1, 1, 8'hA0, 32'h2500_3400, 1, 2'd1, 5'd0, "R8");
    cyc(1, 1, 8'hA0, 32'h0100_2600, 1, 2'd3, 5'd0, "R8");
    cyc(1, 1, 8'hA0, 32'h0000_3000, 1, 2'd0, 5'd0, "R8");
    cyc(1, 1, 8'h80, KEY, 1, 2'd1, 5'd0, "R8");
    cyc(1, 1, 8'hA0, 32'h3F00_0000, 0, 0, 5'd0, "R8");
    cyc(1, 1, 8'h80, KEY, 1, 2'd2, 5'd0, "R8");
    // mixed traffic
    for (int i = 0; i < 200; i++) begin
      logic [7:0] ad;
      case ((i * 7) % 6)
        0: ad = 8'h80; 1: ad = 8'hA0; 2: ad = 8'hA4;
        3: ad = 8'hFC; 4: ad = 8'hA0; default: ad = 8'(i * 13);
      endcase
      cyc((i % 5) != 0, (i % 3) == 0, ad, (i % 17 == 0) ? KEY : 32'(i * 32'h9E37_79B9),
          (i % 4) == 1, 2'(i / 3), 5'(i / 7), "R8");
    end
    idle(2, 5'd0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R1 watchdog act=%h exp=%h", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule